// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core, together with the status register that the core's branch and carry logic read. Each cycle it takes two byte operands, an operation code and a short unsigned immediate. It produces a byte result, a word result and a result-write strobe. It also presents the status byte that the operation would leave behind. When `exec_en` is high, that status byte is captured on the next rising clock edge.

Each operation owns a fixed subset of the flags. Flags outside that subset keep their value. The sign flag always follows negative xor overflow, which makes signed comparisons a single-bit test. The word operations add a short immediate to a 16-bit register pair, or subtract it from the pair. The pair is formed from the two byte operands, with `op_b` as the high byte. A direct load port writes the whole status byte, for example when the core restores it after an interrupt. The register file, the decoder and the branch logic stay outside.

Top module: `byte_alu_status`

## Requirements
- R1: Codes 0 (add) and 1 (add with carry in from C) return A+B and A+B+C. They update H (carry out of bit 3), V (signed overflow), N (result bit 7), Z (result zero), C (carry out of bit 7) and S. Status bit order from 7 down to 0 is I, T, H, S, V, N, Z, C. After every operation that updates V, S equals N xor V.
- R2: Codes 2 (subtract) and 3 (subtract with borrow C) return A-B and A-B-C. They update H (borrow into bit 4), V, N, C (borrow out of bit 7), S and Z. For code 3, Z is set only when the result is zero and Z was already set.
- R3: Codes 4 and 5 compare. They set the flags exactly as codes 2 and 3 would, and they hold `res_wr` low. Every other defined code except the unused ones drives `res_wr` high.
- R4: Codes 6 (AND), 7 (OR) and 8 (XOR) update Z, N and S and clear V. C and H keep their values.
- R5: Code 9 returns 0xFF-A, sets C to 1 and clears V. Code 10 returns 0x00-A. It sets C when A is nonzero, sets V when A is 0x80, and sets H when the low nibble of A is nonzero. Both codes update N, Z and S.
- R6: Codes 11 (increment) and 12 (decrement) change A by one and update Z, N, V and S. V is set for 0x7F to 0x80 and for 0x80 to 0x7F. C and H keep their values.
- R7: Codes 13 (logical shift right, 0 enters bit 7), 14 (rotate right, old C enters bit 7) and 15 (arithmetic shift right, bit 7 kept) set C from A bit 0. They update N and Z, and set V to N xor C.
- R8: Code 16 exchanges the two nibbles of A and leaves the whole status byte unchanged.
- R9: Code 17 adds and code 18 subtracts the zero-extended `imm_k` on the pair {op_b, op_a}. The 16-bit result appears on `result_w`, with its low byte on `result`. Both codes update Z, N (bit 15), C, V and S from the 16-bit values and leave H unchanged.
- R10: No operation alters I or T. With `exec_en` and `stat_wr` low, the status register holds. `stat_wr` loads `stat_din` on the next edge and takes priority over `exec_en`.
- R11: While `rst_n` is low, the status register is cleared to 0x00 on the clock edge.
- R12: Codes 19 to 31 are unused. They drive `result` and `result_w` to zero and hold `res_wr` low. Executing them changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Capture the updated status on the next edge |
| op_sel | input | 5 | Operation code |
| op_a | input | 8 | First operand; low byte of the word pair |
| op_b | input | 8 | Second operand; high byte of the word pair |
| imm_k | input | 6 | Unsigned immediate for word operations |
| stat_wr | input | 1 | Load the status register from `stat_din` |
| stat_din | input | 8 | Status value to load |
| result | output | 8 | Byte result |
| result_w | output | 16 | Word result; zero-extended byte result for byte operations |
| res_wr | output | 1 | High when the result is meant to be written back |
| stat_nxt | output | 8 | Status byte after the current operation |
| stat_q | output | 8 | Registered status byte |

## Verification
The bench builds the block with its defaults: an 8-bit datapath, a 6-bit immediate and the word unit enabled. With 8-bit operands, random draws quickly reach every carry, half-carry and overflow boundary. A 6-bit immediate lets the word operations cross the 0x7FFF/0x8000 and 0xFFFF/0x0000 edges of the pair. Directed cases cover the sticky zero of the borrow forms and the preserved carry of the logic and step operations. They also cover the load-over-execute priority, and the random stream mixes status loads so that every flag combination feeds the carry-dependent codes.

// File: rtl/bas_pkg.sv
package bas_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CP   = 5'd4,
      OP_CPC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_COM  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_LSR  = 5'd13,
      OP_ROR  = 5'd14,
      OP_ASR  = 5'd15,
      OP_SWAP = 5'd16,
      OP_WADD = 5'd17,
      OP_WSUB = 5'd18
   } op_e;

   // status bit positions (order is seen by the branch logic)
   localparam int FB_C = 0;
   localparam int FB_Z = 1;
   localparam int FB_N = 2;
   localparam int FB_V = 3;
   localparam int FB_S = 4;
   localparam int FB_H = 5;
   localparam int FB_T = 6;
   localparam int FB_I = 7;
   localparam int SW   = 8;

   typedef struct packed {
      logic h;
      logic v;
      logic n;
      logic z;
      logic c;
   } flg_t;

   localparam logic [SW-1:0] MSK_ARITH = 8'b0011_1111;
   localparam logic [SW-1:0] MSK_SVNZC = 8'b0001_1111;
   localparam logic [SW-1:0] MSK_SVNZ  = 8'b0001_1110;

   function automatic logic [SW-1:0] upd_mask(input op_e op);
      logic [SW-1:0] m;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC,
         OP_CP, OP_CPC, OP_NEG:          m = MSK_ARITH;
         OP_AND, OP_OR, OP_XOR,
         OP_INC, OP_DEC:                 m = MSK_SVNZ;
         OP_COM, OP_LSR, OP_ROR, OP_ASR,
         OP_WADD, OP_WSUB:               m = MSK_SVNZC;
         default:                        m = '0;
      endcase
      return m;
   endfunction

   function automatic logic is_arith(input op_e op);
      return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC,
                         OP_NEG, OP_INC, OP_DEC});
   endfunction

   function automatic logic is_bitop(input op_e op);
      return (op inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_LSR, OP_ROR,
                         OP_ASR, OP_SWAP});
   endfunction

   function automatic logic is_word(input op_e op);
      return (op inside {OP_WADD, OP_WSUB});
   endfunction

endpackage

// File: rtl/bas_arith.sv
module bas_arith
   import bas_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   input  logic          zin,
   output logic [DW-1:0] res,
   output flg_t          fl
);

   localparam int NB = 4;

   logic [DW-1:0] x, y, yy;
   logic          sub, ci, cc, sticky;
   logic [DW:0]   wide;
   logic [NB:0]   nib;

   always_comb begin
      x      = a;
      y      = b;
      sub    = 1'b0;
      ci     = 1'b0;
      sticky = 1'b0;
      case (op)
         OP_ADD: ;
         OP_ADC: ci = cin;
         OP_SUB, OP_CP: sub = 1'b1;
         OP_SBC, OP_CPC: begin
            sub    = 1'b1;
            ci     = cin;
            sticky = 1'b1;
         end
         OP_NEG: begin
            sub = 1'b1;
            x   = '0;
            y   = a;
         end
         OP_INC: y = {{(DW-1){1'b0}}, 1'b1};
         OP_DEC: begin
            sub = 1'b1;
            y   = {{(DW-1){1'b0}}, 1'b1};
         end
         default: begin
            x = '0;
            y = '0;
         end
      endcase
   end

   // one carry chain: subtraction is x + ~y + !borrow_in
   assign yy   = sub ? ~y : y;
   assign cc   = sub ? ~ci : ci;
   assign wide = {1'b0, x} + {1'b0, yy} + {{DW{1'b0}}, cc};
   assign nib  = {1'b0, x[NB-1:0]} + {1'b0, yy[NB-1:0]} + {{NB{1'b0}}, cc};
   assign res  = wide[DW-1:0];

   always_comb begin
      fl.c = sub ? ~wide[DW] : wide[DW];
      fl.h = sub ? ~nib[NB] : nib[NB];
      fl.n = res[DW-1];
      fl.v = (x[DW-1] == yy[DW-1]) && (res[DW-1] != x[DW-1]);
      fl.z = (res == '0) && (!sticky || zin);
   end

endmodule

// File: rtl/bas_bitops.sv
module bas_bitops
   import bas_pkg::*;
#(
   parameter int DW = 8
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   output logic [DW-1:0] res,
   output flg_t          fl
);

   localparam int HW = DW / 2;

   logic shift_op;

   always_comb begin
      shift_op = 1'b0;
      fl.c     = cin;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_COM: begin
            res  = ~a;
            fl.c = 1'b1;
         end
         OP_LSR: begin
            res      = {1'b0, a[DW-1:1]};
            fl.c     = a[0];
            shift_op = 1'b1;
         end
         OP_ROR: begin
            res      = {cin, a[DW-1:1]};
            fl.c     = a[0];
            shift_op = 1'b1;
         end
         OP_ASR: begin
            res      = {a[DW-1], a[DW-1:1]};
            fl.c     = a[0];
            shift_op = 1'b1;
         end
         OP_SWAP: res = {a[HW-1:0], a[DW-1:HW]};
         default: res = '0;
      endcase
      fl.n = res[DW-1];
      fl.z = (res == '0);
      fl.h = 1'b0;
      fl.v = shift_op ? (res[DW-1] ^ fl.c) : 1'b0;
   end

endmodule

// File: rtl/bas_wordop.sv
module bas_wordop
   import bas_pkg::*;
#(
   parameter int DW = 8,
   parameter int KW = 6
) (
   input  op_e             op,
   input  logic [2*DW-1:0] pair,
   input  logic [KW-1:0]   k,
   output logic [2*DW-1:0] res,
   output flg_t            fl
);

   localparam int WW = 2 * DW;

   logic [WW-1:0] kx;
   logic          sub, ph, rh;

   assign kx  = {{(WW-KW){1'b0}}, k};
   assign sub = (op == OP_WSUB);
   assign res = sub ? (pair - kx) : (pair + kx);
   assign ph  = pair[WW-1];
   assign rh  = res[WW-1];

   always_comb begin
      fl.h = 1'b0;
      fl.n = rh;
      fl.z = (res == '0);
      if (sub) begin
         fl.v = ph & ~rh;
         fl.c = rh & ~ph;
      end else begin
         fl.v = ~ph & rh;
         fl.c = ph & ~rh;
      end
   end

endmodule

// File: rtl/bas_statreg.sv
module bas_statreg
   import bas_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exec_en,
   input  logic          load_en,
   input  logic [SW-1:0] load_val,
   input  logic [SW-1:0] mask,
   input  flg_t          fl_new,
   output logic [SW-1:0] q,
   output logic [SW-1:0] nxt
);

   logic [SW-1:0] cand;

   always_comb begin
      cand       = q;
      cand[FB_C] = fl_new.c;
      cand[FB_Z] = fl_new.z;
      cand[FB_N] = fl_new.n;
      cand[FB_V] = fl_new.v;
      cand[FB_S] = fl_new.n ^ fl_new.v;
      cand[FB_H] = fl_new.h;
   end

   for (genvar i = 0; i < SW; i++) begin : g_bit
      assign nxt[i] = mask[i] ? cand[i] : q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (load_en) q <= load_val;
      else if (exec_en) q <= nxt;
   end

endmodule

// File: rtl/byte_alu_status.sv
module byte_alu_status
   import bas_pkg::*;
#(
   parameter int DW       = 8,
   parameter int KW       = 6,
   parameter bit HAS_WORD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exec_en,
   input  logic [4:0]      op_sel,
   input  logic [DW-1:0]   op_a,
   input  logic [DW-1:0]   op_b,
   input  logic [KW-1:0]   imm_k,
   input  logic            stat_wr,
   input  logic [SW-1:0]   stat_din,
   output logic [DW-1:0]   result,
   output logic [2*DW-1:0] result_w,
   output logic            res_wr,
   output logic [SW-1:0]   stat_nxt,
   output logic [SW-1:0]   stat_q
);

   localparam int WW = 2 * DW;

   if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
      $error("byte_alu_status: DW must be even and at least 8");
   end
   if (KW < 1 || KW > WW) begin : g_bad_kw
      $error("byte_alu_status: KW out of range");
   end

   op_e           op;
   logic [DW-1:0] ar_res, bo_res;
   logic [WW-1:0] wd_res;
   flg_t          ar_fl, bo_fl, wd_fl, sel_fl;
   logic [SW-1:0] mask;
   logic          word_ok;

   assign op      = op_e'(op_sel);
   assign word_ok = HAS_WORD && is_word(op);

   bas_arith #(.DW(DW)) u_arith (
      .op  (op),
      .a   (op_a),
      .b   (op_b),
      .cin (stat_q[FB_C]),
      .zin (stat_q[FB_Z]),
      .res (ar_res),
      .fl  (ar_fl)
   );

   bas_bitops #(.DW(DW)) u_bitops (
      .op  (op),
      .a   (op_a),
      .b   (op_b),
      .cin (stat_q[FB_C]),
      .res (bo_res),
      .fl  (bo_fl)
   );

   if (HAS_WORD) begin : g_word
      bas_wordop #(.DW(DW), .KW(KW)) u_word (
         .op   (op),
         .pair ({op_b, op_a}),
         .k    (imm_k),
         .res  (wd_res),
         .fl   (wd_fl)
      );
   end else begin : g_noword
      assign wd_res = '0;
      assign wd_fl  = '0;
   end

   always_comb begin
      result   = '0;
      result_w = '0;
      sel_fl   = '0;
      res_wr   = 1'b0;
      mask     = '0;
      if (is_arith(op)) begin
         result   = ar_res;
         result_w = {{DW{1'b0}}, ar_res};
         sel_fl   = ar_fl;
         res_wr   = !(op inside {OP_CP, OP_CPC});
         mask     = upd_mask(op);
      end else if (is_bitop(op)) begin
         result   = bo_res;
         result_w = {{DW{1'b0}}, bo_res};
         sel_fl   = bo_fl;
         res_wr   = 1'b1;
         mask     = upd_mask(op);
      end else if (word_ok) begin
         result   = wd_res[DW-1:0];
         result_w = wd_res;
         sel_fl   = wd_fl;
         res_wr   = 1'b1;
         mask     = upd_mask(op);
      end
   end

   bas_statreg u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .exec_en  (exec_en),
      .load_en  (stat_wr),
      .load_val (stat_din),
      .mask     (mask),
      .fl_new   (sel_fl),
      .q        (stat_q),
      .nxt      (stat_nxt)
   );

endmodule

// File: rtl/bas_checker.sv
module bas_checker
   import bas_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       exec_en,
   input logic [4:0] op_sel,
   input logic       stat_wr,
   input logic [7:0] stat_din,
   input logic       res_wr,
   input logic [7:0] stat_q
);

   logic run;
   assign run = exec_en && !stat_wr;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> stat_q == 8'h00);                                       // R11

   AST_S_FOLLOWS_NV: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op_sel <= 5'd15) |=> stat_q[FB_S] == (stat_q[FB_N] ^ stat_q[FB_V])); // R1

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_CP || op_sel == OP_CPC) |-> !res_wr);                 // R3

   AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op_sel == OP_SWAP) |=> $stable(stat_q));                    // R8

   AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (op_sel == OP_INC || op_sel == OP_DEC || op_sel == OP_AND ||
               op_sel == OP_OR || op_sel == OP_XOR))
      |=> stat_q[FB_C] == $past(stat_q[FB_C]));                           // R6

   AST_COM_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op_sel == OP_COM) |=> stat_q[FB_C] && !stat_q[FB_V]);       // R5

   AST_IT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> stat_q[7:6] == $past(stat_q[7:6]));                         // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en && !stat_wr) |=> $stable(stat_q));                        // R10

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> stat_q == $past(stat_din));                             // R10

   AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel >= 5'd19) |-> !res_wr);                                     // R12

endmodule

bind byte_alu_status bas_checker chk_i (.*);

// File: tb/byte_alu_status_tb_top.sv
module byte_alu_status_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [4:0]  op_sel = '0;
   logic [7:0]  op_a = '0;
   logic [7:0]  op_b = '0;
   logic [5:0]  imm_k = '0;
   logic        stat_wr = 1'b0;
   logic [7:0]  stat_din = '0;
   logic [7:0]  result;
   logic [15:0] result_w;
   logic        res_wr;
   logic [7:0]  stat_nxt;
   logic [7:0]  stat_q;

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;
   logic [7:0] exp_q = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_alu_status dut_i (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
      .op_a(op_a), .op_b(op_b), .imm_k(imm_k), .stat_wr(stat_wr),
      .stat_din(stat_din), .result(result), .result_w(result_w),
      .res_wr(res_wr), .stat_nxt(stat_nxt), .stat_q(stat_q)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int sg8(input int x);
      return (x > 127) ? x - 256 : x;
   endfunction

   function automatic string req_of(input int op);
      case (op)
         0, 1:        return "R1";
         2, 3:        return "R2";
         4, 5:        return "R3";
         6, 7, 8:     return "R4";
         9, 10:       return "R5";
         11, 12:      return "R6";
         13, 14, 15:  return "R7";
         16:          return "R8";
         17, 18:      return "R9";
         default:     return "R12";
      endcase
   endfunction

   // expected behaviour, written from the requirements
   function automatic void ref_op(input int op, input int a, input int b, input int k,
                                  input logic [7:0] sq, output logic [15:0] r16,
                                  output logic wr, output logic [7:0] nx);
      int r, ci, s, sv, p, sp;
      bit h, v, c, n, z, zs, wide;
      logic [7:0] m;
      r = 0; h = 0; v = 0; c = 0; zs = 1; wide = 0; m = 8'h00; wr = 1;
      case (op)
         0, 1: begin
            ci = (op == 1) ? int'(sq[0]) : 0;
            s = a + b + ci; r = s & 255;
            h = ((a & 15) + (b & 15) + ci) > 15;
            c = s > 255;
            sv = sg8(a) + sg8(b) + ci; v = (sv > 127) || (sv < -128);
            m = 8'h3F;
         end
         2, 3, 4, 5: begin
            ci = (op == 3 || op == 5) ? int'(sq[0]) : 0;
            s = a - b - ci; r = s & 255;
            h = (a & 15) < ((b & 15) + ci);
            c = s < 0;
            sv = sg8(a) - sg8(b) - ci; v = (sv > 127) || (sv < -128);
            if (op == 3 || op == 5) zs = sq[1];
            if (op == 4 || op == 5) wr = 0;
            m = 8'h3F;
         end
         6: begin r = a & b; m = 8'h1E; end
         7: begin r = a | b; m = 8'h1E; end
         8: begin r = a ^ b; m = 8'h1E; end
         9: begin r = 255 - a; c = 1; m = 8'h1F; end
         10: begin
            r = (256 - a) & 255; h = (a & 15) != 0; c = a != 0; v = a == 128;
            m = 8'h3F;
         end
         11: begin r = (a + 1) & 255; v = a == 127; m = 8'h1E; end
         12: begin r = (a + 255) & 255; v = a == 128; m = 8'h1E; end
         13: begin r = a >> 1; c = (a & 1) != 0; m = 8'h1F; end
         14: begin r = (int'(sq[0]) * 128) | (a >> 1); c = (a & 1) != 0; m = 8'h1F; end
         15: begin r = (a & 128) | (a >> 1); c = (a & 1) != 0; m = 8'h1F; end
         16: r = ((a & 15) << 4) | (a >> 4);
         17, 18: begin
            p = b * 256 + a; sp = (p >= 32768) ? p - 65536 : p;
            if (op == 17) begin
               s = p + k; c = s > 65535; v = (sp + k) > 32767;
            end else begin
               s = p - k; c = s < 0; v = (sp - k) < -32768;
            end
            r = s & 65535; wide = 1; m = 8'h1F;
         end
         default: begin wr = 0; r = 0; end
      endcase
      n = wide ? ((r >> 15) & 1) != 0 : ((r >> 7) & 1) != 0;
      z = (r == 0) && zs;
      if (op >= 13 && op <= 15) v = n ^ c;
      nx = sq;
      if (m[0]) nx[0] = c;
      if (m[1]) nx[1] = z;
      if (m[2]) nx[2] = n;
      if (m[3]) nx[3] = v;
      if (m[4]) nx[4] = n ^ v;
      if (m[5]) nx[5] = h;
      r16 = r[15:0];
   endfunction

   task automatic load_stat(input logic [7:0] v);
      @(negedge clk);
      stat_wr = 1; stat_din = v; exec_en = 0;
      @(posedge clk); #1;
      stat_wr = 0;
      exp_q = v;
      chk(stat_q == v, "R10", "status load", stat_q, v);
   endtask

   task automatic run_op(input int op, input int a, input int b, input int k,
                         input bit en);
      logic [15:0] r16;
      logic        wr;
      logic [7:0]  nx;
      string       rq;
      rq = req_of(op);
      @(negedge clk);
      op_sel = op[4:0]; op_a = a[7:0]; op_b = b[7:0]; imm_k = k[5:0];
      exec_en = en; stat_wr = 0;
      ref_op(op, a, b, k, exp_q, r16, wr, nx);
      #1;
      chk(result == r16[7:0], rq, "result", result, r16[7:0]);
      chk(result_w == r16, rq, "result_w", result_w, r16);
      chk(res_wr == wr, rq, "res_wr", res_wr, wr);
      chk(stat_nxt == nx, rq, "stat_nxt", stat_nxt, nx);
      @(posedge clk); #1;
      if (en) exp_q = nx;
      chk(stat_q == exp_q, en ? rq : "R10", "stat_q", stat_q, exp_q);
      exec_en = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0A1B));
      repeat (3) @(posedge clk);
      #1;
      chk(stat_q == 8'h00, "R11", "reset status", stat_q, 8'h00);
      rst_n = 1;

      // R1 add corners
      load_stat(8'h00);
      run_op(0, 8'h08, 8'h08, 0, 1);
      run_op(0, 8'h7F, 8'h01, 0, 1);
      run_op(0, 8'hFF, 8'h01, 0, 1);
      load_stat(8'h01);
      run_op(1, 8'h0F, 8'h00, 0, 1);
      // R2 subtract, sticky zero
      run_op(2, 8'h10, 8'h01, 0, 1);
      load_stat(8'h00);
      run_op(3, 8'h00, 8'h00, 0, 1);
      load_stat(8'h03);
      run_op(3, 8'h01, 8'h00, 0, 1);
      // R3 compare
      run_op(4, 8'h80, 8'h01, 0, 1);
      load_stat(8'h02);
      run_op(5, 8'h22, 8'h22, 0, 1);
      // R4 logic keeps C and H
      load_stat(8'h29);
      run_op(6, 8'hF0, 8'h0F, 0, 1);
      run_op(7, 8'h80, 8'h01, 0, 1);
      run_op(8, 8'h5A, 8'h5A, 0, 1);
      // R5 complement, negate
      run_op(9, 8'h00, 0, 0, 1);
      run_op(10, 8'h80, 0, 0, 1);
      run_op(10, 8'h00, 0, 0, 1);
      run_op(10, 8'h10, 0, 0, 1);
      // R6 step with carry preset
      load_stat(8'h01);
      run_op(11, 8'h7F, 0, 0, 1);
      run_op(12, 8'h80, 0, 0, 1);
      run_op(11, 8'hFF, 0, 0, 1);
      // R7 shifts
      run_op(13, 8'h01, 0, 0, 1);
      load_stat(8'h01);
      run_op(14, 8'h02, 0, 0, 1);
      run_op(15, 8'h81, 0, 0, 1);
      // R8 swap
      load_stat(8'h3F);
      run_op(16, 8'hA5, 0, 0, 1);
      // R9 word
      run_op(17, 8'hFF, 8'hFF, 1, 1);
      run_op(18, 8'h00, 8'h00, 1, 1);
      run_op(17, 8'hFF, 8'h7F, 1, 1);
      run_op(18, 8'h00, 8'h80, 63, 1);
      // R10 I and T survive, idle hold, load priority
      load_stat(8'hC0);
      run_op(0, 8'hFF, 8'hFF, 0, 1);
      run_op(2, 8'h00, 8'h01, 0, 0);
      @(negedge clk);
      op_sel = 5'd0; op_a = 8'hFF; op_b = 8'h01; exec_en = 1; stat_wr = 1; stat_din = 8'h44;
      @(posedge clk); #1;
      exec_en = 0; stat_wr = 0; exp_q = 8'h44;
      chk(stat_q == 8'h44, "R10", "load over execute", stat_q, 8'h44);
      // R12 unused codes
      run_op(19, 8'h12, 8'h34, 5, 1);
      run_op(31, 8'hFF, 8'hFF, 63, 1);

      for (int i = 0; i < N_RAND; i++) begin
         if (($urandom % 8) == 0) load_stat(8'($urandom));
         run_op(int'($urandom_range(0, 21)), int'($urandom % 256),
                int'($urandom % 256), int'($urandom % 64), ($urandom % 6) != 0);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule